// File: doc/BRIEF.md
# Audio Converter Control Register and Reset Sequencer

This block is the configuration front end of an audio digital-to-analog converter. A host writes 16-bit words over a write-only serial port (clock, data and a latch strobe); the block decodes the word aimed at its control register and keeps the fields. It then merges them with static strap pins to form the operating settings for the datapath. These settings are oversampling rate, right-justified word length, mute, serial audio format and de-emphasis curve.

The block also runs the converter's reset sequence. An active-low reset pin clears the stored fields, holds the datapath and forces midscale output. A control bit gives a soft reset that holds the datapath without clearing storage. After either reset is released, a ready flag returns only once a fixed pipeline latency plus three master clocks has elapsed. A reset pulse that is too short is flagged. A change of the effective serial format mutes the output for a short programmable time so that switching transients are suppressed.

All inputs are asynchronous to the master clock and pass through two-flop synchronisers. The serial clock is oversampled, so each of its levels must last at least three master-clock periods.

Top module: `dac_ctl_top`

## Requirements
- R1: A word is shifted in MSB first on serial-clock rising edges and is taken on the rising edge of the latch strobe. Only words whose bits [1:0] equal 01 update the control fields. Words with any other value in bits [1:0] leave every output unchanged.
- R2: Word bit 11 requests 2x oversampling and bit 10 requests 4x. Each effective output is the OR of its bit and its own strap pin.
- R3: Word bits [9:8] give the right-justified length code: 00 is 24 bits, 01 is 20 bits and 10 is 16 bits. The unused code 11 is presented as 00.
- R4: The effective mute is the OR of word bit 6, the mute pin and the format-change mute of R11.
- R5: Word bits [5:4] are ORed with the two format pins to give the format code: 00 is right-justified, 01 is I2S, 10 is left-justified and 11 is DSP.
- R6: Word bits [3:2] choose the de-emphasis curve: 00 is off, 01 is 44.1 kHz, 10 is 32 kHz and 11 is 48 kHz. A high de-emphasis pin overrides the field and forces 01.
- R7: While the synchronised reset pin is low, the stored fields return to 0 and serial words are discarded. During this time dp_hold and force_mid are high and ready is low.
- R8: After the synchronised reset pin goes high, or after the soft-reset bit is cleared, ready rises exactly LAT+3 master clocks later. dp_hold is always the inverse of ready, and force_mid falls together with ready rising.
- R9: At each reset release, short_rst is set if the pin was low for fewer than MIN_LOW (64) master clocks and cleared otherwise. It keeps that value until the next release.
- R10: While word bit 7 (soft reset) is stored, every register field contributes its default of 0 while the pins still apply. During this time dp_hold is high, ready is low and force_mid is not raised. The fields of that word are still stored.
- R11: When the effective format code changes, mute is high from that cycle through MUTE_CLKS further cycles.
- R12: A strap-pin change reaches the effective outputs on the second master-clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| spi_sclk | input | 1 | Serial port clock |
| spi_mosi | input | 1 | Serial port data, MSB first |
| spi_latch | input | 1 | Word latch strobe, rising edge takes the word |
| pin_x2 | input | 1 | Strap: request 2x oversampling |
| pin_x4 | input | 1 | Strap: request 4x oversampling |
| pin_mute | input | 1 | Strap: mute |
| pin_fmt | input | 2 | Strap: serial format bits |
| pin_deemph | input | 1 | Strap: force 44.1 kHz de-emphasis |
| eff_x2 | output | 1 | Effective 2x oversampling |
| eff_x4 | output | 1 | Effective 4x oversampling |
| eff_wlen | output | 2 | Effective right-justified length code |
| eff_mute | output | 1 | Effective mute |
| eff_fmt | output | 2 | Effective serial format code |
| eff_deemph | output | 2 | Effective de-emphasis curve code |
| dp_hold | output | 1 | Datapath hold |
| force_mid | output | 1 | Force midscale output (hardware reset) |
| ready | output | 1 | Normal operation running |
| short_rst | output | 1 | Last reset pulse was too short |

## Verification
A wrong stored field or a missed decode shows at the effective outputs on the very clock after the word is taken, because those outputs are combinational from the stored state and the synchronised pins. A countdown that is off by one shows as ready rising a cycle early or late, and a lost format-change count shows as mute dropping before its window ends. A reference model that steps every master clock therefore catches each such fault in the cycle it appears, rather than only at the end of a scenario.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;

    // Bits of a serial word that the block keeps: [11:0]. Higher bits carry no field.
    localparam int unsigned KEEP_W = 12;
    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 2'b01;

    // Field order mirrors word bits [11:2] so a slice converts directly.
    typedef struct packed {
        logic       x2;
        logic       x4;
        logic [1:0] wlen;
        logic       srst;
        logic       mute;
        logic [1:0] fmt;
        logic [1:0] demp;
    } ctl_t;

    typedef struct packed {
        logic       x2;
        logic       x4;
        logic       mute;
        logic       demp;
        logic [1:0] fmt;
    } strap_t;

    localparam int unsigned STRAP_W = $bits(strap_t);

    function automatic ctl_t ctl_from_word(input logic [KEEP_W-1:0] w);
        return ctl_t'(w[KEEP_W-1:ADDR_W]);
    endfunction

endpackage

// File: rtl/dac_ctl_sync.sv
module dac_ctl_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        sy_q <= sy_d;
    end

    assign q = sy_q.s2;
endmodule

// File: rtl/dac_ctl_spi_rx.sv
module dac_ctl_spi_rx
    import dac_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              run,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              latch,
    output logic              vld,
    output logic [KEEP_W-1:0] word
);
    typedef struct packed {
        logic              sclk_p;
        logic              latch_p;
        logic              vld;
        logic [KEEP_W-1:0] shift;
        logic [KEEP_W-1:0] word;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d         = rx_q;
        rx_d.sclk_p  = sclk;
        rx_d.latch_p = latch;
        rx_d.vld     = 1'b0;
        if (!run) begin
            rx_d.shift = '0;
        end else begin
            if (sclk && !rx_q.sclk_p) begin
                rx_d.shift = {rx_q.shift[KEEP_W-2:0], mosi};
            end
            if (latch && !rx_q.latch_p) begin
                rx_d.vld  = 1'b1;
                rx_d.word = rx_q.shift;
            end
        end
    end

    always_ff @(posedge clk) begin
        rx_q <= rx_d;
    end

    assign vld  = rx_q.vld;
    assign word = rx_q.word;
endmodule

// File: rtl/dac_ctl_seq.sv
module dac_ctl_seq #(
    parameter int unsigned LAT     = 8,
    parameter int unsigned MIN_LOW = 64
) (
    input  logic clk,
    input  logic run,
    input  logic srst,
    output logic ready,
    output logic dp_hold,
    output logic force_mid,
    output logic short_rst
);
    localparam int unsigned REL = LAT + 3;
    localparam int unsigned CW  = $clog2(REL + 1);
    localparam int unsigned LW  = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [LW-1:0] low;
        logic          viol;
        logic          rdy;
        logic          hw;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (!run) begin
            if (sq_q.low != LW'(MIN_LOW)) begin
                sq_d.low = sq_q.low + 1'b1;
            end
            sq_d.cnt = CW'(REL);
            sq_d.rdy = 1'b0;
            sq_d.hw  = 1'b1;
        end else begin
            if (sq_q.low != '0) begin
                sq_d.viol = (sq_q.low < LW'(MIN_LOW));
            end
            sq_d.low = '0;
            if (srst) begin
                sq_d.cnt = CW'(REL);
                sq_d.rdy = 1'b0;
            end else begin
                if (sq_q.cnt <= CW'(1)) begin
                    sq_d.rdy = 1'b1;
                    sq_d.hw  = 1'b0;
                end
                if (sq_q.cnt != '0) begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        sq_q <= sq_d;
    end

    assign ready     = sq_q.rdy;
    assign dp_hold   = !sq_q.rdy;
    assign force_mid = sq_q.hw;
    assign short_rst = sq_q.viol;
endmodule

// File: rtl/dac_ctl_top.sv
module dac_ctl_top
    import dac_ctl_pkg::*;
#(
    parameter int unsigned LAT       = 8,
    parameter int unsigned MIN_LOW   = 64,
    parameter int unsigned MUTE_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst_pin_n,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    input  logic       spi_latch,
    input  logic       pin_x2,
    input  logic       pin_x4,
    input  logic       pin_mute,
    input  logic [1:0] pin_fmt,
    input  logic       pin_deemph,
    output logic       eff_x2,
    output logic       eff_x4,
    output logic [1:0] eff_wlen,
    output logic       eff_mute,
    output logic [1:0] eff_fmt,
    output logic [1:0] eff_deemph,
    output logic       dp_hold,
    output logic       force_mid,
    output logic       ready,
    output logic       short_rst
);
    localparam int unsigned MW = $clog2(MUTE_CLKS + 1);

    // Asynchronous inputs into the master-clock domain
    logic [3:0] ctl_raw, ctl_s;
    strap_t     st_raw, st_s;
    logic       rst_s, sclk_s, mosi_s, latch_s;

    assign ctl_raw = {rst_pin_n, spi_sclk, spi_mosi, spi_latch};
    assign st_raw  = '{x2: pin_x2, x4: pin_x4, mute: pin_mute, demp: pin_deemph, fmt: pin_fmt};

    dac_ctl_sync #(.W(4)) i_sync_ctl (
        .clk (clk),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    dac_ctl_sync #(.W(STRAP_W)) i_sync_strap (
        .clk (clk),
        .d   (st_raw),
        .q   (st_s)
    );

    assign {rst_s, sclk_s, mosi_s, latch_s} = ctl_s;

    // Serial word capture
    logic              rx_vld;
    logic [KEEP_W-1:0] rx_word;

    dac_ctl_spi_rx i_rx (
        .clk   (clk),
        .run   (rst_s),
        .sclk  (sclk_s),
        .mosi  (mosi_s),
        .latch (latch_s),
        .vld   (rx_vld),
        .word  (rx_word)
    );

    // Control storage and format-change mute
    typedef struct packed {
        ctl_t          ctrl;
        logic [1:0]    fmt_p;
        logic [MW-1:0] mcnt;
    } top_t;

    top_t tp_d, tp_q;
    ctl_t reg_v;
    logic fmt_chg;
    logic soft_rst;

    assign soft_rst = tp_q.ctrl.srst;

    always_comb begin
        reg_v = soft_rst ? ctl_t'('0) : tp_q.ctrl;
    end

    assign eff_x2     = reg_v.x2 | st_s.x2;
    assign eff_x4     = reg_v.x4 | st_s.x4;
    assign eff_wlen   = (reg_v.wlen == 2'b11) ? 2'b00 : reg_v.wlen;
    assign eff_fmt    = reg_v.fmt | st_s.fmt;
    assign eff_deemph = st_s.demp ? 2'b01 : reg_v.demp;
    assign fmt_chg    = (eff_fmt != tp_q.fmt_p);
    assign eff_mute   = reg_v.mute | st_s.mute | fmt_chg | (tp_q.mcnt != '0);

    always_comb begin
        tp_d       = tp_q;
        tp_d.fmt_p = eff_fmt;
        if (!rst_s) begin
            tp_d.ctrl = '0;
            tp_d.mcnt = '0;
        end else begin
            if (rx_vld && (rx_word[ADDR_W-1:0] == CTL_ADDR)) begin
                tp_d.ctrl = ctl_from_word(rx_word);
            end
            if (fmt_chg) begin
                tp_d.mcnt = MW'(MUTE_CLKS);
            end else if (tp_q.mcnt != '0) begin
                tp_d.mcnt = tp_q.mcnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        tp_q <= tp_d;
    end

    // Reset sequencing
    dac_ctl_seq #(.LAT(LAT), .MIN_LOW(MIN_LOW)) i_seq (
        .clk       (clk),
        .run       (rst_s),
        .srst      (soft_rst),
        .ready     (ready),
        .dp_hold   (dp_hold),
        .force_mid (force_mid),
        .short_rst (short_rst)
    );
endmodule

// File: rtl/dac_ctl_chk.sv
module dac_ctl_chk #(
    parameter int unsigned REL = 11
) (
    input logic       clk,
    input logic       rst_s,
    input logic       soft_rst,
    input logic       rx_vld,
    input logic [1:0] addr,
    input logic [9:0] ctrl,
    input logic       ready,
    input logic       force_mid,
    input logic       dp_hold,
    input logic [1:0] eff_fmt,
    input logic       eff_mute
);
    localparam int unsigned RW = $clog2(REL + 2);

    // Cycles since the last edge that saw either reset active
    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_s || soft_rst) begin
            run_cnt <= '0;
        end else if (run_cnt != RW'(REL + 1)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_ignore_addr_R1: assert property (@(posedge clk) disable iff (!rst_s)
        (rx_vld && addr != 2'b01) |=> $stable(ctrl));

    assert_mid_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_s)
        force_mid |-> dp_hold);

    assert_ready_latency_R8: assert property (@(posedge clk) disable iff (!rst_s)
        $rose(ready) |-> (run_cnt == RW'(REL)));

    assert_soft_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_s)
        soft_rst |=> !ready);

    assert_fmt_change_mutes_R11: assert property (@(posedge clk) disable iff (!rst_s)
        !$stable(eff_fmt) |-> eff_mute);
endmodule

bind dac_ctl_top dac_ctl_chk #(.REL(LAT + 3)) i_chk (
    .clk       (clk),
    .rst_s     (rst_s),
    .soft_rst  (soft_rst),
    .rx_vld    (rx_vld),
    .addr      (rx_word[1:0]),
    .ctrl      (tp_q.ctrl),
    .ready     (ready),
    .force_mid (force_mid),
    .dp_hold   (dp_hold),
    .eff_fmt   (eff_fmt),
    .eff_mute  (eff_mute)
);

// File: tb/test_dac_ctl_top.sv
module test_dac_ctl_top;
    localparam int LAT = 8;
    localparam int REL = LAT + 3;
    localparam int MIN_LOW = 64;
    localparam int MUTE = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_pin_n = 1'b0;
    logic       sclk = 1'b0, mosi = 1'b0, latch = 1'b0;
    logic [5:0] straps = 6'b0; // {x2, x4, mute, deemph, fmt[1:0]}

    logic       eff_x2, eff_x4, eff_mute, dp_hold, force_mid, ready, short_rst;
    logic [1:0] eff_wlen, eff_fmt, eff_deemph;

    dac_ctl_top #(.LAT(LAT), .MIN_LOW(MIN_LOW), .MUTE_CLKS(MUTE)) i_dac_ctl_top (
        .clk(clk), .rst_pin_n(rst_pin_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_latch(latch),
        .pin_x2(straps[5]), .pin_x4(straps[4]), .pin_mute(straps[3]), .pin_fmt(straps[1:0]),
        .pin_deemph(straps[2]),
        .eff_x2(eff_x2), .eff_x4(eff_x4), .eff_wlen(eff_wlen), .eff_mute(eff_mute),
        .eff_fmt(eff_fmt), .eff_deemph(eff_deemph), .dp_hold(dp_hold), .force_mid(force_mid),
        .ready(ready), .short_rst(short_rst)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic        l_rst = 0, s_rst = 0, l_sck = 0, s_sck = 0, l_mo = 0, s_mo = 0, l_la = 0, s_la = 0;
    logic [5:0]  l_st = 0, s_st = 0;
    logic        m_sckp = 0, m_lap = 0, m_vld = 0;
    logic [15:0] m_shift = 0, m_word = 0, m_cw = 0;
    int          m_cnt = 0, m_low = 0, m_mcnt = 0;
    logic        m_viol = 0, m_ready = 0, m_hw = 0;
    logic [1:0]  m_fmtp = 0;

    function automatic logic [15:0] regbits(input logic [15:0] cw);
        return cw[7] ? 16'h0 : cw;
    endfunction

    function automatic logic [1:0] f_fmt(input logic [15:0] cw, input logic [5:0] st);
        logic [15:0] rb;
        rb = regbits(cw);
        return rb[5:4] | st[1:0];
    endfunction

    always @(posedge clk) begin
        logic o_rst, o_sck, o_mo, o_la, o_srst, n_vld, chg;
        logic [5:0]  o_st;
        logic [15:0] n_word;
        logic [1:0]  o_fmt;
        o_rst = s_rst; o_sck = s_sck; o_mo = s_mo; o_la = s_la; o_st = s_st;
        o_srst = m_cw[7];
        o_fmt = f_fmt(m_cw, o_st);
        chg = (o_fmt != m_fmtp);
        // two-stage input delay
        s_rst = l_rst; s_sck = l_sck; s_mo = l_mo; s_la = l_la; s_st = l_st;
        l_rst = rst_pin_n; l_sck = sclk; l_mo = mosi; l_la = latch; l_st = straps;
        // word capture
        n_vld = o_rst && o_la && !m_lap;
        n_word = m_shift;
        if (!o_rst) m_shift = 0;
        else if (o_sck && !m_sckp) m_shift = {m_shift[14:0], o_mo};
        m_sckp = o_sck; m_lap = o_la;
        if (!o_rst) m_cw = 0;
        else if (m_vld && m_word[1:0] == 2'b01) m_cw = {4'h0, m_word[11:0]};
        m_vld = n_vld; m_word = n_word;
        // reset sequencing
        if (!o_rst) begin
            if (m_low < MIN_LOW) m_low++;
            m_cnt = REL; m_ready = 0; m_hw = 1;
        end else begin
            if (m_low != 0) m_viol = (m_low < MIN_LOW);
            m_low = 0;
            if (o_srst) begin
                m_cnt = REL; m_ready = 0;
            end else begin
                if (m_cnt <= 1) begin m_ready = 1; m_hw = 0; end
                if (m_cnt != 0) m_cnt--;
            end
        end
        // format-change mute
        m_fmtp = o_fmt;
        if (!o_rst) m_mcnt = 0;
        else if (chg) m_mcnt = MUTE;
        else if (m_mcnt != 0) m_mcnt--;
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            logic [15:0] rb;
            logic [1:0]  wl, ef;
            rb = regbits(m_cw);
            wl = (rb[9:8] == 2'b11) ? 2'b00 : rb[9:8];
            ef = f_fmt(m_cw, s_st);
            chk("R2 eff_x2", 16'(eff_x2), 16'(rb[11] | s_st[5]));
            chk("R2 eff_x4", 16'(eff_x4), 16'(rb[10] | s_st[4]));
            chk("R3 eff_wlen", 16'(eff_wlen), 16'(wl));
            chk("R5 eff_fmt", 16'(eff_fmt), 16'(ef));
            chk("R6 eff_deemph", 16'(eff_deemph), 16'(s_st[2] ? 2'b01 : rb[3:2]));
            chk("R4 R11 eff_mute", 16'(eff_mute),
                16'(rb[6] | s_st[3] | (ef != m_fmtp) | (m_mcnt != 0)));
            chk("R8 ready", 16'(ready), 16'(m_ready));
            chk("R8 dp_hold", 16'(dp_hold), 16'(!m_ready));
            chk("R7 force_mid", 16'(force_mid), 16'(m_hw));
            chk("R9 short_rst", 16'(short_rst), 16'(m_viol));
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [15:0] mk(input bit x2, input bit x4, input logic [1:0] wl,
                                       input bit sr, input bit mu, input logic [1:0] fm,
                                       input logic [1:0] de, input logic [1:0] ad);
        return {4'hA, x2, x4, wl, sr, mu, fm, de, ad};
    endfunction

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; mosi = w[i];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sclk = 1'b0;
        latch = 1'b1;
        repeat (4) @(negedge clk);
        latch = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic hw_reset(input int n);
        @(negedge clk); rst_pin_n = 1'b0;
        repeat (n) @(negedge clk);
        rst_pin_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(4);
        cmp_en = 1'b1;
        wait_n(96);
        // R7: reset state
        chk("R7 force_mid in reset", 16'(force_mid), 16'h1);
        chk("R7 dp_hold in reset", 16'(dp_hold), 16'h1);
        chk("R7 ready in reset", 16'(ready), 16'h0);
        rst_pin_n = 1'b1;
        wait_n(REL);
        chk("R8 ready not before latency", 16'(ready), 16'h0);
        wait_n(2);
        chk("R8 ready after latency", 16'(ready), 16'h1);
        chk("R9 long pulse", 16'(short_rst), 16'h0);

        // R2 R3 R5 R6 R11: first configuration
        send_word(mk(1, 0, 2'b01, 0, 0, 2'b01, 2'b10, 2'b01));
        chk("R11 mute after format change", 16'(eff_mute), 16'h1);
        chk("R2 x2 from word", 16'(eff_x2), 16'h1);
        chk("R3 wlen 20", 16'(eff_wlen), 16'h1);
        chk("R5 fmt I2S", 16'(eff_fmt), 16'h1);
        chk("R6 deemph 32k", 16'(eff_deemph), 16'h2);
        wait_n(20);
        chk("R11 mute window over", 16'(eff_mute), 16'h0);

        // R1: other addresses ignored
        send_word(mk(0, 1, 2'b10, 0, 1, 2'b11, 2'b11, 2'b10));
        send_word(mk(0, 1, 2'b10, 0, 1, 2'b11, 2'b11, 2'b00));
        send_word(mk(0, 1, 2'b10, 0, 1, 2'b11, 2'b11, 2'b11));
        chk("R1 ignored x2", 16'(eff_x2), 16'h1);
        chk("R1 ignored fmt", 16'(eff_fmt), 16'h1);
        chk("R1 ignored mute", 16'(eff_mute), 16'h0);

        // R3 R4 R6: length codes, mute bit, 48k
        send_word(mk(0, 1, 2'b11, 0, 1, 2'b01, 2'b11, 2'b01));
        chk("R3 code 11 as 24", 16'(eff_wlen), 16'h0);
        chk("R4 mute bit", 16'(eff_mute), 16'h1);
        chk("R6 deemph 48k", 16'(eff_deemph), 16'h3);
        send_word(mk(0, 0, 2'b10, 0, 0, 2'b01, 2'b00, 2'b01));
        chk("R3 wlen 16", 16'(eff_wlen), 16'h2);

        // R12 R2 R5 R6 R4: straps
        @(negedge clk); straps = 6'b010110; // x4, deemph, fmt 10
        chk("R12 not yet", 16'(eff_x4), 16'h0);
        @(negedge clk);
        chk("R12 still old after one edge", 16'(eff_x4), 16'h0);
        @(negedge clk);
        chk("R12 x4 after two edges", 16'(eff_x4), 16'h1);
        chk("R5 fmt OR with pins", 16'(eff_fmt), 16'h3);
        chk("R6 pin forces 44k", 16'(eff_deemph), 16'h1);
        wait_n(25);
        straps = 6'b001000;
        wait_n(25);
        chk("R4 mute pin", 16'(eff_mute), 16'h1);
        straps = 6'b000000;
        wait_n(25);

        // R10: soft reset
        send_word(mk(1, 0, 2'b01, 1, 0, 2'b10, 2'b01, 2'b01));
        chk("R10 hold in soft reset", 16'(dp_hold), 16'h1);
        chk("R10 ready low", 16'(ready), 16'h0);
        chk("R10 no midscale", 16'(force_mid), 16'h0);
        chk("R10 x2 default", 16'(eff_x2), 16'h0);
        chk("R10 fmt default", 16'(eff_fmt), 16'h0);
        wait_n(30);
        send_word(mk(1, 0, 2'b01, 0, 0, 2'b10, 2'b01, 2'b01));
        chk("R10 R8 still held", 16'(ready), 16'h0);
        wait_n(10);
        chk("R10 R8 resumed", 16'(ready), 16'h1);
        chk("R10 fields back", 16'(eff_x2), 16'h1);

        // R9 R7: reset pulse lengths, words dropped during reset
        hw_reset(30);
        wait_n(20);
        chk("R9 short pulse flagged", 16'(short_rst), 16'h1);
        chk("R7 fields cleared", 16'(eff_x2), 16'h0);
        hw_reset(63);
        wait_n(20);
        chk("R9 63 clocks is short", 16'(short_rst), 16'h1);
        hw_reset(64);
        wait_n(20);
        chk("R9 64 clocks is enough", 16'(short_rst), 16'h0);
        @(negedge clk); rst_pin_n = 1'b0;
        send_word(mk(1, 1, 2'b01, 0, 1, 2'b11, 2'b11, 2'b01));
        rst_pin_n = 1'b1;
        wait_n(20);
        chk("R7 word in reset dropped", 16'(eff_x4), 16'h0);
        chk("R7 ready again", 16'(ready), 16'h1);
        wait_n(5);
        finish_run();
    end
endmodule